// File: doc/BRIEF.md
# Glitch-Free Programmable Output Divider

This block sits behind the oscillator of a clock synthesizer and derives the output clock from the oscillator clock (nominally 400 to 800 MHz). A 2-bit select picks a ratio of 1, 2, 4 or 8, so the output spans 50 to 800 MHz. A power-down request slows the output by a further factor of 16. An active-high enable parks the output, with the true output low and the complement high.

Every mode change waits for a clean output period boundary. An internal phase counter wraps once per output period. Only at that wrap are the select, enable and power-down inputs captured into the active mode, while the output is already in its low half. A pulse on the output is therefore either full width or absent. In divide-by-1 mode the output is the oscillator clock gated through a latch that is transparent while the clock is low.

Top module: `clk_out_divider`

## Requirements
- R1: `div_sel` encodes the ratio as 2'b11 = 1, 2'b00 = 2, 2'b01 = 4, 2'b10 = 8 oscillator cycles per output period (power-down off).
- R2: In divided modes the output is high for the first half of each period and low for the second half, a 50% duty cycle starting at the counter wrap.
- R3: `out_en` is captured only at a period boundary. While the captured value is 0, `fout` is low and `fout_n` is high.
- R4: `fout_n` is always the complement of `fout`.
- R5: A change of `div_sel` takes effect only at the next counter wrap. Until then the current period completes with the old ratio.
- R6: With `pwr_down` captured as 1, the period is 16 times the selected ratio. The change is applied at a period boundary.
- R7: In divide-by-1 mode (2'b11, power-down off), `fout` follows the oscillator clock, gated by a latch that is transparent while the clock is low. The first high phase after entering the mode is suppressed.
- R8: A synchronous reset clears the counter, selects divide-by-2 with power-down off, and disables the output, so `fout` is low and `fout_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Ratio select (encoding in R1) |
| out_en | input | 1 | Active-high output enable |
| pwr_down | input | 1 | Requests a further divide by 16 |
| fout | output | 1 | Divided clock, true polarity |
| fout_n | output | 1 | Divided clock, complement |

## Verification
The assertions assume that `div_sel`, `out_en` and `pwr_down` are stable around the rising oscillator edge, so each is sampled cleanly once per cycle. They also assume that reset is held across at least one rising edge before any output is judged. The bench changes all control inputs only on the falling edge and holds reset for three cycles. Several changes are deliberately placed mid-period, so the deferral to the wrap is exercised rather than assumed.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int BASE_LOG_MAX = 3;
    localparam int PD_LOG       = 4;
    localparam int CNT_W        = BASE_LOG_MAX + PD_LOG;

    typedef enum logic [1:0] {
        DIV_BY2 = 2'b00,
        DIV_BY4 = 2'b01,
        DIV_BY8 = 2'b10,
        DIV_BY1 = 2'b11
    } ratio_e;

    typedef struct packed {
        logic   en;
        logic   pd;
        ratio_e ratio;
    } mode_t;

    localparam mode_t MODE_RESET = '{en: 1'b0, pd: 1'b0, ratio: DIV_BY2};

    function automatic int ratio_log(ratio_e r);
        case (r)
            DIV_BY2: return 1;
            DIV_BY4: return 2;
            DIV_BY8: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [CNT_W:0] period_len(mode_t m);
        int lg;
        lg = ratio_log(m.ratio) + (m.pd ? PD_LOG : 0);
        return (CNT_W+1)'(1) << lg;
    endfunction

    function automatic logic [CNT_W-1:0] period_last(mode_t m);
        logic [CNT_W:0] p;
        p = period_len(m) - (CNT_W+1)'(1);
        return p[CNT_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] half_len(mode_t m);
        logic [CNT_W:0] p;
        p = period_len(m) >> 1;
        return p[CNT_W-1:0];
    endfunction

    function automatic logic is_bypass(mode_t m);
        return (m.ratio == DIV_BY1) && !m.pd;
    endfunction

endpackage

// File: rtl/clkdiv_mode_reg.sv
module clkdiv_mode_reg
    import clkdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wrap,
    input  mode_t mode_in,
    output mode_t mode_d,
    output mode_t mode_q
);
    always_comb begin
        mode_d = wrap ? mode_in : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RESET;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             wrap
);
    always_comb begin
        wrap  = (cnt_q == period_last(mode_q));
        cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode_q,
    input  mode_t            mode_d,
    input  logic [CNT_W-1:0] cnt_d,
    output logic             div_q,
    output logic             fout
);
    logic byp;
    logic gate_l;

    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= mode_d.en && (cnt_d < half_len(mode_d));
    end

    always_comb begin
        byp = is_bypass(mode_q);
    end

    always_latch begin
        if (!clk) gate_l = mode_q.en && byp;
    end

    always_comb begin
        fout = byp ? (clk && gate_l) : div_q;
    end
endmodule

// File: rtl/clk_out_divider.sv
module clk_out_divider
    import clkdiv_pkg::*;
(
    input  logic       clk_vco,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       out_en,
    input  logic       pwr_down,
    output logic       fout,
    output logic       fout_n
);
    mode_t            mode_in;
    mode_t            mode_d;
    mode_t            mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             wrap;
    logic             div_q;

    always_comb begin
        mode_in.en    = out_en;
        mode_in.pd    = pwr_down;
        mode_in.ratio = ratio_e'(div_sel);
    end

    clkdiv_mode_reg u_mode (
        .clk(clk_vco), .rst(rst), .wrap(wrap),
        .mode_in(mode_in), .mode_d(mode_d), .mode_q(mode_q)
    );

    clkdiv_phase_cnt u_cnt (
        .clk(clk_vco), .rst(rst), .mode_q(mode_q),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
    );

    clkdiv_out_stage u_out (
        .clk(clk_vco), .rst(rst), .mode_q(mode_q), .mode_d(mode_d),
        .cnt_d(cnt_d), .div_q(div_q), .fout(fout)
    );

    always_comb begin
        fout_n = !fout;
    end
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt_q,
    input mode_t            mode_q,
    input logic             div_q,
    input logic             fout,
    input logic             fout_n
);
    a_r4_complement: assert property (@(posedge clk) disable iff (rst)
        fout_n == !fout);

    a_r5_mode_held: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(mode_q));

    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> (cnt_q == '0));

    a_r3_parked_low: assert property (@(posedge clk) disable iff (rst)
        (wrap && !en_i) |=> !div_q);

    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= period_last(mode_q));

    a_r7_divider_idle: assert property (@(posedge clk) disable iff (rst)
        is_bypass(mode_q) |-> !div_q);
endmodule

bind clk_out_divider clkdiv_chk u_chk (
    .clk(clk_vco), .rst(rst), .en_i(out_en), .wrap(wrap), .cnt_q(cnt_q),
    .mode_q(mode_q), .div_q(div_q), .fout(fout), .fout_n(fout_n)
);

// File: tb/tb_clk_out_divider.sv
module tb_clk_out_divider;
    logic       clk_vco = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       out_en = 1'b0;
    logic       pwr_down = 1'b0;
    logic       fout;
    logic       fout_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit started  = 0;
    bit finished = 0;

    // reference model state
    int m_cnt = 0, m_sel = 0, m_pd = 0, m_en = 0;
    int m_out = 0;

    clk_out_divider dut (
        .clk_vco(clk_vco), .rst(rst), .div_sel(div_sel), .out_en(out_en),
        .pwr_down(pwr_down), .fout(fout), .fout_n(fout_n)
    );

    always #2 clk_vco = !clk_vco;   // 250 MHz

    function automatic int ratio_of(int s);
        // R1: 11 -> 1, 00 -> 2, 01 -> 4, 10 -> 8
        case (s)
            0: return 2;
            1: return 4;
            2: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int period_of(int s, int pd);
        return ratio_of(s) * (pd != 0 ? 16 : 1);
    endfunction

    task automatic check(input logic act, input int exp, input string req);
        n_checks++;
        if (act !== exp[0]) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %b expected %0d", req, $time, act, exp);
        end
    endtask

    always @(posedge clk_vco) begin
        int  gate_prev;
        int  byp;
        int  pending;
        int  exp_f;
        string tag;
        gate_prev = ((m_sel == 3) && (m_pd == 0)) ? m_en : 0;
        if (rst) begin
            m_cnt = 0; m_sel = 0; m_pd = 0; m_en = 0; m_out = 0;
            started = 1;
        end else begin
            if (m_cnt == period_of(m_sel, m_pd) - 1) begin
                m_cnt = 0; m_sel = div_sel; m_pd = pwr_down; m_en = out_en;
            end else begin
                m_cnt++;
            end
            m_out = (m_en != 0 && m_cnt < period_of(m_sel, m_pd) / 2) ? 1 : 0;
        end
        byp     = ((m_sel == 3) && (m_pd == 0)) ? 1 : 0;
        exp_f   = (byp != 0) ? gate_prev : m_out;
        pending = (int'(div_sel) != m_sel) ? 1 : 0;
        #1;
        if (started && !finished) begin
            if (rst)               tag = "R8";
            else if (byp != 0)     tag = "R7";
            else if (m_en == 0)    tag = "R3";
            else if (pending != 0) tag = "R5";
            else if (m_pd != 0)    tag = "R6";
            else                   tag = "R1 R2";
            check(fout, exp_f, tag);
            check(fout_n, 1 - exp_f, "R4");
        end
    end

    task automatic drive(input int sel, input int en, input int pd, input int cycles);
        @(negedge clk_vco);
        div_sel  = sel[1:0];
        out_en   = en[0];
        pwr_down = pd[0];
        for (int i = 1; i < cycles; i++) @(negedge clk_vco);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #200000;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk_vco);
        rst = 1'b0;
        drive(0, 0, 0, 10);     // R8: stays parked after reset
        drive(0, 1, 0, 40);     // R1 R2: divide by 2
        drive(1, 1, 0, 51);     // R5: change lands mid-period
        drive(2, 1, 0, 63);     // divide by 8
        drive(3, 1, 0, 30);     // R7: bypass
        drive(3, 0, 0, 7);      // R7 disable in bypass
        drive(3, 1, 0, 9);
        drive(0, 1, 0, 21);     // leave bypass
        drive(2, 1, 1, 300);    // R6: power-down on divide by 8
        drive(3, 1, 1, 100);    // R6: power-down on divide by 1
        drive(1, 0, 0, 37);     // R3: disable
        drive(1, 1, 0, 45);
        drive(0, 1, 1, 3);      // short power-down pulse, may miss the wrap
        drive(0, 1, 0, 40);
        for (int k = 0; k < 40; k++) drive(k % 4, 1, 0, 3);   // R5: rapid select churn
        drive(2, 1, 0, 20);
        @(negedge clk_vco);
        rst = 1'b1;             // R8: reset mid-run
        drive(2, 1, 0, 4);
        rst = 1'b0;
        drive(2, 1, 0, 40);
        finish_run();
    end
endmodule